// File: doc/BRIEF.md
# Longest-First Prefix Search Controller

This block sequences one longest-prefix-match search per destination address. Once it has been started, it asks the address source for an address, has the hash unit produce the hash code for all prefix lengths, and then probes prefix lengths one at a time. It starts at the full address width and moves toward shorter lengths. For each length it has the index selector pick that length's indices and queries an on-chip membership filter. When the filter answers negative, the controller only steps the length down by one. When the filter answers positive, the controller checks that length against the exact-match hash table. If the table rejects the entry, the filter answer was a false positive and the search moves on to the next shorter length. The first length the table confirms ends the search.

The CRC generator, the membership filter and the hash table sit outside the block. Each one is driven through a request signal that stays high until its one-cycle response arrives. The block reports each finished search with a one-cycle done strobe. Alongside the strobe it reports either a match flag with the confirmed output port, or a no-match flag. These result values are held until the next strobe. After each result the controller goes straight back to fetching the next address.

Top module: `lpm_search_ctrl`

## Requirements
- R1: While `rst_n` is low, `done`, `match`, `nomatch`, `port`, `qlen` and every request output are 0.
- R2: After reset the block idles with `fetch_req` low until `go` is sampled high. From the next cycle on, `fetch_req` is high, and it stays high until `fetch_ack` is sampled.
- R3: Each accepted address reloads the query length to W. The first filter query for that address is made with `qlen` equal to W.
- R4: After a fetch, `crc_req` is held until `crc_ack`. Then `idx_sel` is high for exactly one cycle, and the filter query for that length follows it.
- R5: A negative filter answer (`bf_neg`) causes no hash table access. The next filter query is made at `qlen` minus one.
- R6: A positive filter answer (`bf_pos`) raises `ht_req` at the same length. A table miss (`ht_miss`) is treated as a false positive, and the search continues one length shorter.
- R7: A table hit (`ht_hit`) ends the search. One cycle later `done` is high for exactly one cycle, with `match` = 1, `nomatch` = 0 and `port` equal to `ht_port` as sampled with the hit. `fetch_req` is high in that same cycle.
- R8: The shortest length probed is MIN_LEN, and `qlen` never drops below it during a search. If the search at MIN_LEN ends negative or as a miss, `done` pulses with `nomatch` = 1, `match` = 0 and `port` = 0.
- R9: `port`, `match` and `nomatch` change only in a cycle where `done` is high.
- R10: Asserting `rst_n` low in the middle of a search returns the block to idle, clears the results, and sets the length to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Starts the search loop from idle |
| fetch_req | output | 1 | Request for the next address |
| fetch_ack | input | 1 | Address delivered (one-cycle pulse) |
| crc_req | output | 1 | Request to compute hash codes for all lengths |
| crc_ack | input | 1 | Hash codes ready (one-cycle pulse) |
| idx_sel | output | 1 | One-cycle strobe: take the indices for `qlen` |
| bf_req | output | 1 | Membership filter query at `qlen` |
| bf_pos | input | 1 | Filter answer: possibly present |
| bf_neg | input | 1 | Filter answer: absent |
| ht_req | output | 1 | Hash table lookup at `qlen` |
| ht_hit | input | 1 | Table holds the prefix |
| ht_miss | input | 1 | Table does not hold the prefix |
| ht_port | input | PW | Port stored with the hit entry |
| qlen | output | $clog2(W+1) | Current query length |
| done | output | 1 | One-cycle end-of-search strobe |
| match | output | 1 | Last search found a prefix |
| nomatch | output | 1 | Last search found no prefix |
| port | output | PW | Port of the last match |

## Verification
The end of one search and the start of the next overlap. On the cycle where the result strobe appears, the controller has already raised its fetch request for the following address. The bench's address model acknowledges on the very next cycle and swaps in a new per-length answer pattern. Each strobe is judged against the prefix the bench computes for the address just finished, and the held result must not move while the next search runs.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_HASH   = 3'd2,
    ST_PICK   = 3'd3,
    ST_FILTER = 3'd4,
    ST_SHRINK = 3'd5,
    ST_VERIFY = 3'd6
  } srch_state_t;

endpackage

// File: rtl/lsc_next_state.sv
module lsc_next_state
  import lsc_pkg::*;
(
  input  srch_state_t cur,
  input  logic        go,
  input  logic        fetch_ack,
  input  logic        crc_ack,
  input  logic        bf_pos,
  input  logic        bf_neg,
  input  logic        ht_hit,
  input  logic        ht_miss,
  input  logic        at_floor,
  output srch_state_t nxt,
  output logic        load_len,
  output logic        dec_len,
  output logic        fin_hit,
  output logic        fin_miss
);

  always_comb begin
    nxt      = cur;
    load_len = 1'b0;
    dec_len  = 1'b0;
    fin_hit  = 1'b0;
    fin_miss = 1'b0;
    unique case (cur)
      ST_IDLE: begin
        if (go) nxt = ST_FETCH;
      end
      ST_FETCH: begin
        if (fetch_ack) begin
          nxt      = ST_HASH;
          load_len = 1'b1;
        end
      end
      ST_HASH: begin
        if (crc_ack) nxt = ST_PICK;
      end
      ST_PICK: begin
        nxt = ST_FILTER;
      end
      ST_FILTER: begin
        if (bf_pos)      nxt = ST_VERIFY;
        else if (bf_neg) nxt = ST_SHRINK;
      end
      ST_VERIFY: begin
        if (ht_hit) begin
          nxt     = ST_FETCH;
          fin_hit = 1'b1;
        end else if (ht_miss) begin
          nxt = ST_SHRINK;
        end
      end
      ST_SHRINK: begin
        if (at_floor) begin
          nxt      = ST_FETCH;
          fin_miss = 1'b1;
        end else begin
          nxt     = ST_PICK;
          dec_len = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/lsc_len_ctr.sv
module lsc_len_ctr #(
  parameter int W       = 32,
  parameter int MIN_LEN = 1,
  localparam int LW     = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_len,
  input  logic          dec_len,
  output logic [LW-1:0] qlen,
  output logic          at_floor
);

  logic [LW-1:0] qlen_d;
  logic          qlen_en;

  assign qlen_en  = load_len | dec_len;
  assign at_floor = (qlen <= LW'(MIN_LEN));

  always_comb begin
    qlen_d = qlen;
    if (load_len)     qlen_d = LW'(W);
    else if (dec_len) qlen_d = qlen - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       qlen <= '0;
    else if (qlen_en) qlen <= qlen_d;
  end

  // R3: every accepted address starts at the full width
  a_r3_load_full: assert property (@(posedge clk) disable iff (!rst_n)
    load_len |=> (qlen == LW'(W)));

  // R5: a decrement steps by exactly one
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_len && !load_len) |=> (qlen == $past(qlen) - 1'b1));

  // R8: a decrement is never requested at or below the floor
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec_len |-> (qlen > LW'(MIN_LEN)));

endmodule

// File: rtl/lsc_result_reg.sv
module lsc_result_reg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin_hit,
  input  logic          fin_miss,
  input  logic [PW-1:0] ht_port,
  output logic          done,
  output logic          match,
  output logic          nomatch,
  output logic [PW-1:0] port
);

  logic res_en;

  assign res_en = fin_hit | fin_miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= res_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match   <= 1'b0;
      nomatch <= 1'b0;
      port    <= '0;
    end else if (res_en) begin
      match   <= fin_hit;
      nomatch <= ~fin_hit;
      port    <= fin_hit ? ht_port : '0;
    end
  end

  // R7: the strobe lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7 / R8: each finished search reports exactly one outcome
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (match ^ nomatch));

  // R9: the result is held between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(port) && $stable(match) && $stable(nomatch)));

endmodule

// File: rtl/lpm_search_ctrl.sv
module lpm_search_ctrl
  import lsc_pkg::*;
#(
  parameter int W       = 32,
  parameter int MIN_LEN = 1,
  parameter int PW      = 8,
  localparam int LW     = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          fetch_req,
  input  logic          fetch_ack,
  output logic          crc_req,
  input  logic          crc_ack,
  output logic          idx_sel,
  output logic          bf_req,
  input  logic          bf_pos,
  input  logic          bf_neg,
  output logic          ht_req,
  input  logic          ht_hit,
  input  logic          ht_miss,
  input  logic [PW-1:0] ht_port,
  output logic [LW-1:0] qlen,
  output logic          done,
  output logic          match,
  output logic          nomatch,
  output logic [PW-1:0] port
);

  srch_state_t state, state_d;
  logic        load_len, dec_len, fin_hit, fin_miss, at_floor;

  lsc_next_state u_nxt (
    .cur       (state),
    .go        (go),
    .fetch_ack (fetch_ack),
    .crc_ack   (crc_ack),
    .bf_pos    (bf_pos),
    .bf_neg    (bf_neg),
    .ht_hit    (ht_hit),
    .ht_miss   (ht_miss),
    .at_floor  (at_floor),
    .nxt       (state_d),
    .load_len  (load_len),
    .dec_len   (dec_len),
    .fin_hit   (fin_hit),
    .fin_miss  (fin_miss)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  lsc_len_ctr #(.W(W), .MIN_LEN(MIN_LEN)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_len (load_len),
    .dec_len  (dec_len),
    .qlen     (qlen),
    .at_floor (at_floor)
  );

  lsc_result_reg #(.PW(PW)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin_hit  (fin_hit),
    .fin_miss (fin_miss),
    .ht_port  (ht_port),
    .done     (done),
    .match    (match),
    .nomatch  (nomatch),
    .port     (port)
  );

  assign fetch_req = (state == ST_FETCH);
  assign crc_req   = (state == ST_HASH);
  assign idx_sel   = (state == ST_PICK);
  assign bf_req    = (state == ST_FILTER);
  assign ht_req    = (state == ST_VERIFY);

  // R4: the index strobe is a single cycle and is followed by a query
  a_r4_pick_then_query: assert property (@(posedge clk) disable iff (!rst_n)
    idx_sel |=> (bf_req && !idx_sel));

  // R8: probing never goes below the shortest length
  a_r8_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (bf_req || ht_req) |-> (qlen >= LW'(MIN_LEN)));

  // R6: a positive filter answer leads to a table lookup
  a_r6_pos_verifies: assert property (@(posedge clk) disable iff (!rst_n)
    (bf_req && bf_pos) |=> ht_req);

  // R5: a negative filter answer never touches the table
  a_r5_neg_no_table: assert property (@(posedge clk) disable iff (!rst_n)
    (bf_req && bf_neg && !bf_pos) |=> !ht_req);

  // R7: a confirmed hit is reported on the next cycle while the next fetch begins
  a_r7_hit_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (ht_req && ht_hit) |=> (done && match && fetch_req));

  // R2: only one request is active at a time
  a_r2_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_req, crc_req, idx_sel, bf_req, ht_req}));

endmodule

// File: tb/lpm_search_ctrl_test.sv
module lpm_search_ctrl_test;

  localparam int W   = 8;
  localparam int MN  = 2;
  localparam int PW  = 4;
  localparam int LW  = $clog2(W + 1);
  localparam int NV  = 7;
  localparam int LIM = 5000;

  // vector = {port[3:0], table hit mask[8:0], filter positive mask[8:0]}, bit i = length i
  localparam logic [21:0] VT [NV] = '{
    {4'd5,  9'b100000000, 9'b100000000},
    {4'd0,  9'b000000000, 9'b000000000},
    {4'd9,  9'b000010000, 9'b001010000},
    {4'd0,  9'b000000000, 9'b110001100},
    {4'd3,  9'b000000100, 9'b000000100},
    {4'd7,  9'b000000010, 9'b000000011},
    {4'd12, 9'b000100000, 9'b000100000}
  };

  logic clk = 1'b0;
  logic rst_n, go;
  logic fetch_req, fetch_ack, crc_req, crc_ack, idx_sel, bf_req, bf_pos, bf_neg;
  logic ht_req, ht_hit, ht_miss, done, match, nomatch;
  logic [PW-1:0] ht_port, port;
  logic [LW-1:0] qlen;

  int checks = 0, errors = 0;
  int vi = -1, ndone = 0, bfc = 0, htc = 0, exp_len = 0;
  logic feed_en = 1'b1;
  logic have_res = 1'b0;
  logic [8:0] cur_bf = '0, cur_ht = '0;
  logic [PW-1:0] cur_port = '0;
  logic hold_m, hold_n;
  logic [PW-1:0] hold_p;

  always #5 clk = ~clk;

  lpm_search_ctrl #(.W(W), .MIN_LEN(MN), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .go(go),
    .fetch_req(fetch_req), .fetch_ack(fetch_ack),
    .crc_req(crc_req), .crc_ack(crc_ack), .idx_sel(idx_sel),
    .bf_req(bf_req), .bf_pos(bf_pos), .bf_neg(bf_neg),
    .ht_req(ht_req), .ht_hit(ht_hit), .ht_miss(ht_miss), .ht_port(ht_port),
    .qlen(qlen), .done(done), .match(match), .nomatch(nomatch), .port(port)
  );

  // behavioural models of the address source, hash unit, filter and table
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_ack <= 1'b0; crc_ack <= 1'b0; bf_pos <= 1'b0; bf_neg <= 1'b0;
      ht_hit <= 1'b0; ht_miss <= 1'b0; ht_port <= '0;
    end else begin
      fetch_ack <= fetch_req && !fetch_ack && feed_en && (vi + 1 < NV);
      crc_ack   <= crc_req && !crc_ack;
      bf_pos    <= bf_req && !(bf_pos || bf_neg) && cur_bf[qlen];
      bf_neg    <= bf_req && !(bf_pos || bf_neg) && !cur_bf[qlen];
      ht_hit    <= ht_req && !(ht_hit || ht_miss) && cur_ht[qlen];
      ht_miss   <= ht_req && !(ht_hit || ht_miss) && !cur_ht[qlen];
      ht_port   <= (ht_req && cur_ht[qlen]) ? cur_port : '0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected outcome computed from the requirements
  task automatic expect_of(input int v, output bit m, output int p,
                           output int nbf, output int nht);
    logic [8:0] bf, ht;
    bf = VT[v][8:0]; ht = VT[v][17:9];
    m = 1'b0; p = 0; nbf = 0; nht = 0;
    for (int l = W; l >= MN; l--) begin
      nbf++;
      if (bf[l]) begin
        nht++;
        if (ht[l]) begin m = 1'b1; p = int'(VT[v][21:18]); break; end
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bf_pos || bf_neg) begin
        check(int'(qlen) == exp_len, "R3/R5 query length", int'(qlen), exp_len);
        check(int'(qlen) >= MN, "R8 floor", int'(qlen), MN);
        exp_len--;
        bfc++;
      end
      if (ht_hit || ht_miss) htc++;
      if (done) begin
        bit em; int ep, ebf, eht;
        expect_of(vi, em, ep, ebf, eht);
        check(match == em, "R7/R8 match flag", int'(match), int'(em));
        check(nomatch == !em, "R8 nomatch flag", int'(nomatch), int'(!em));
        check(int'(port) == ep, "R7 port", int'(port), ep);
        check(bfc == ebf, "R5 filter query count", bfc, ebf);
        check(htc == eht, "R6 table access count", htc, eht);
        check(fetch_req == 1'b1, "R7 next fetch with done", int'(fetch_req), 1);
        hold_m = match; hold_n = nomatch; hold_p = port;
        have_res = 1'b1;
        ndone++;
      end else if (have_res) begin
        check(match == hold_m && nomatch == hold_n && port == hold_p,
              "R9 result held", int'({match, nomatch, port}), int'({hold_m, hold_n, hold_p}));
      end
      if (fetch_ack) begin
        vi++;
        cur_bf = VT[vi][8:0]; cur_ht = VT[vi][17:9]; cur_port = VT[vi][21:18];
        exp_len = W; bfc = 0; htc = 0;
      end
    end
  end

  initial begin
    int cyc;
    rst_n = 1'b0; go = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !match && !nomatch, "R1 result flags", int'({done, match, nomatch}), 0);
    check(port == '0 && qlen == '0, "R1 port and length", int'({port, qlen}), 0);
    check(!fetch_req && !crc_req && !idx_sel && !bf_req && !ht_req, "R1 requests",
          int'({fetch_req, crc_req, idx_sel, bf_req, ht_req}), 0);
    rst_n = 1'b1;
    // R2: idle until go
    repeat (4) @(negedge clk);
    check(!fetch_req, "R2 idle without go", int'(fetch_req), 0);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(fetch_req, "R2 fetch after go", int'(fetch_req), 1);
    // R4: hash request then one index strobe
    cyc = 0;
    while (!crc_req && cyc < LIM) begin @(negedge clk); cyc++; end
    check(crc_req, "R4 hash request", int'(crc_req), 1);
    while (crc_req && cyc < LIM) begin @(negedge clk); cyc++; end
    check(idx_sel, "R4 index strobe", int'(idx_sel), 1);
    @(negedge clk);
    check(!idx_sel && bf_req, "R4 query after strobe", int'({idx_sel, bf_req}), 1);
    // table walk
    cyc = 0;
    while (ndone < NV && cyc < LIM) begin @(negedge clk); cyc++; end
    check(ndone == NV, "R7 all searches finished", ndone, NV);
    // R10: reset while waiting for an address
    repeat (3) @(negedge clk);
    check(fetch_req && match, "R10 pre-reset state", int'({fetch_req, match}), 3);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    have_res = 1'b0;
    repeat (3) @(negedge clk);
    check(!fetch_req && !match && !nomatch && qlen == '0, "R10 back to idle",
          int'({fetch_req, match, nomatch, qlen}), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule